// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block sequences the start-up of a buck regulator's control loop. It runs from the PWM oscillator clock. A start request first holds the error amplifier in reset through a compensation-short strobe for one fixed phase. It then ramps a digital reference code from zero to full scale over a second phase of equal length. When the ramp ends, the code stays at full scale and a one-cycle completion flag is raised.

Once the ramp has finished, an undervoltage flag is acted on only while the run-qualify input says the platform is in its run state. A qualified undervoltage turns every output off for three phase lengths. The block then starts a fresh soft-start on its own, and it keeps repeating this hiccup cycle for as long as the fault persists. An abort input returns the block to idle from any phase and clears its timing. The DAC, the error amplifier and the comparator that produces the undervoltage flag lie outside the block.

Each phase lasts 2^CODE_W clocks. The default CODE_W of 11 gives 2048 clocks per phase, about 8.2 ms at 250 kHz.

Top module: `ss_softstart_seq`

## Requirements
- R1: While reset is asserted, and in idle after reset, comp_short_o, ramp_done_o and reg_en_o are 0 and ref_code_o is 0.
- R2: When start_i is sampled high in idle, then from the next cycle comp_short_o and reg_en_o are 1 and ref_code_o is 0 for exactly 2^CODE_W cycles.
- R3: The ramp follows the clamp directly. For 2^CODE_W cycles ref_code_o equals the number of cycles elapsed in the ramp (0, 1, ... 2^CODE_W-1), with comp_short_o at 0 and reg_en_o at 1.
- R4: In the cycle after the ramp's last cycle, ref_code_o is all ones and ramp_done_o is 1 for that one cycle only. ref_code_o then holds all ones while reg_en_o stays 1.
- R5: When uv_i and run_ok_i are both sampled high after ramp completion, all outputs are 0 for exactly 3*2^CODE_W cycles. A new clamp phase then starts without any start request.
- R6: If the undervoltage is still present after a retry's ramp completes, the hiccup hold and retry repeat. Once uv_i is low, the retry ends in a steady full-scale state.
- R7: uv_i has no effect during the clamp and ramp phases.
- R8: uv_i has no effect while run_ok_i is low.
- R9: When abort_i is sampled high, all outputs are 0 from the next cycle in any phase. A later start runs the full clamp and ramp from count zero.
- R10: start_i has no effect outside idle.
- R11: abort_i takes priority over start_i when both are sampled high in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on in idle |
| abort_i | input | 1 | Return to idle and clear timing |
| uv_i | input | 1 | Undervoltage flag from the comparator |
| run_ok_i | input | 1 | Qualifies undervoltage monitoring (run state) |
| comp_short_o | output | 1 | Error-amplifier reset strobe |
| ref_code_o | output | CODE_W | Digital reference code for the DAC |
| ramp_done_o | output | 1 | One-cycle pulse when the ramp completes |
| reg_en_o | output | 1 | Regulator enable |

## Verification
The hardest situation to reach is a second hiccup caused by an undervoltage that never clears. The stimulus must keep uv_i high through a whole hold and retry. It then has to confirm that the retry's completion cycle is followed directly by another full-length hold and not by a steady output. The bench uses a 4-bit code, which gives 16-clock phases. This keeps every clamp, ramp and hold short enough to check cycle by cycle, with the expected code computed from the cycle offset. Aborts are placed at chosen offsets inside each phase, and each abort is followed by a full restart to show that the count really restarts from zero.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {
    SS_IDLE   = 3'd0,
    SS_CLAMP  = 3'd1,
    SS_RAMP   = 3'd2,
    SS_ACTIVE = 3'd3,
    SS_HICCUP = 3'd4
  } ss_state_e;
endpackage

// File: rtl/ss_phase_timer.sv
module ss_phase_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import ss_seq_pkg::*;
#(
  parameter int unsigned CODE_W      = 11,
  parameter int unsigned HOLD_PHASES = 3,
  parameter int unsigned CNT_W       = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             uv_i,
  input  logic             run_ok_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ss_state_e        state_o,
  output logic             cnt_en_o,
  output logic             cnt_clr_o,
  output logic             done_o
);
  localparam int unsigned PHASE_LEN = 1 << CODE_W;
  localparam int unsigned HOLD_LEN  = HOLD_PHASES * PHASE_LEN;
  localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(PHASE_LEN - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_LEN - 1);

  ss_state_e state_q, state_d;
  logic      done_q, done_d;
  logic      phase_end, hold_end;

  assign phase_end = (cnt_i == PHASE_LAST);
  assign hold_end  = (cnt_i == HOLD_LAST);

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    done_d    = 1'b0;
    if (abort_i) begin
      state_d   = SS_IDLE;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        SS_IDLE: begin
          cnt_clr_o = 1'b1;
          if (start_i) state_d = SS_CLAMP;
        end
        SS_CLAMP: begin
          if (phase_end) begin
            state_d   = SS_RAMP;
            cnt_clr_o = 1'b1;
          end
        end
        SS_RAMP: begin
          if (phase_end) begin
            state_d   = SS_ACTIVE;
            cnt_clr_o = 1'b1;
            done_d    = 1'b1;
          end
        end
        SS_ACTIVE: begin
          cnt_clr_o = 1'b1;
          if (uv_i && run_ok_i) state_d = SS_HICCUP;
        end
        SS_HICCUP: begin
          if (hold_end) begin
            state_d   = SS_CLAMP;
            cnt_clr_o = 1'b1;
          end
        end
        default: begin
          state_d   = SS_IDLE;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  assign cnt_en_o = (state_q == SS_CLAMP) || (state_q == SS_RAMP) ||
                    (state_q == SS_HICCUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ss_out_decode.sv
module ss_out_decode
  import ss_seq_pkg::*;
#(
  parameter int unsigned CODE_W = 11,
  parameter int unsigned CNT_W  = 13
) (
  input  ss_state_e         state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              done_i,
  output logic              comp_short_o,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              ramp_done_o,
  output logic              reg_en_o
);
  always_comb begin
    comp_short_o = 1'b0;
    ref_code_o   = '0;
    reg_en_o     = 1'b0;
    unique case (state_i)
      SS_CLAMP: begin
        comp_short_o = 1'b1;
        reg_en_o     = 1'b1;
      end
      SS_RAMP: begin
        ref_code_o = cnt_i[CODE_W-1:0];
        reg_en_o   = 1'b1;
      end
      SS_ACTIVE: begin
        ref_code_o = '1;
        reg_en_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign ramp_done_o = done_i;
endmodule

// File: rtl/ss_softstart_seq.sv
module ss_softstart_seq
  import ss_seq_pkg::*;
#(
  parameter int unsigned CODE_W      = 11,
  parameter int unsigned HOLD_PHASES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              uv_i,
  input  logic              run_ok_i,
  output logic              comp_short_o,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              ramp_done_o,
  output logic              reg_en_o
);
  localparam int unsigned HOLD_LEN = HOLD_PHASES * (1 << CODE_W);
  localparam int unsigned CNT_W    = $clog2(HOLD_LEN);

  ss_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_en, cnt_clr, done;

  ss_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (cnt_en),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  ss_seq_fsm #(
    .CODE_W      (CODE_W),
    .HOLD_PHASES (HOLD_PHASES),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .uv_i      (uv_i),
    .run_ok_i  (run_ok_i),
    .cnt_i     (cnt),
    .state_o   (state),
    .cnt_en_o  (cnt_en),
    .cnt_clr_o (cnt_clr),
    .done_o    (done)
  );

  ss_out_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .state_i      (state),
    .cnt_i        (cnt),
    .done_i       (done),
    .comp_short_o (comp_short_o),
    .ref_code_o   (ref_code_o),
    .ramp_done_o  (ramp_done_o),
    .reg_en_o     (reg_en_o)
  );
endmodule

// File: rtl/ss_softstart_seq_chk.sv
module ss_softstart_seq_chk #(
  parameter int unsigned CODE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              uv_i,
  input logic              comp_short_o,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              ramp_done_o,
  input logic              reg_en_o
);
  // R2
  clamp_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_short_o |-> (reg_en_o && ref_code_o == '0));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done_o |=> !ramp_done_o);

  // R4
  done_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done_o |-> (ref_code_o == '1 && reg_en_o && !comp_short_o));

  // R9
  abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!reg_en_o && !comp_short_o && ref_code_o == '0 && !ramp_done_o));

  // R3
  ramp_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en_o && !comp_short_o && !abort_i) |=> (!reg_en_o || ref_code_o >= $past(ref_code_o)));

  // R7
  clamp_uv_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_short_o && uv_i && !abort_i) |=> reg_en_o);
endmodule

bind ss_softstart_seq ss_softstart_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .abort_i      (abort_i),
  .uv_i         (uv_i),
  .comp_short_o (comp_short_o),
  .ref_code_o   (ref_code_o),
  .ramp_done_o  (ramp_done_o),
  .reg_en_o     (reg_en_o)
);

// File: tb/ss_softstart_seq_bench.sv
module ss_softstart_seq_bench;
  localparam int CW   = 4;
  localparam int L    = 1 << CW;
  localparam int MAXC = L - 1;
  localparam int HP   = 3;

  logic clk = 1'b0;
  logic rst_n, start_i, abort_i, uv_i, run_ok_i;
  logic comp_short_o, ramp_done_o, reg_en_o;
  logic [CW-1:0] ref_code_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  ss_softstart_seq #(.CODE_W(CW), .HOLD_PHASES(HP)) u_ss_softstart_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .uv_i         (uv_i),
    .run_ok_i     (run_ok_i),
    .comp_short_o (comp_short_o),
    .ref_code_o   (ref_code_o),
    .ramp_done_o  (ramp_done_o),
    .reg_en_o     (reg_en_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit cs, input int rf, input bit dn, input bit en, input string rq);
    logic [CW-1:0] rfe;
    rfe = rf[CW-1:0];
    checks++;
    if (comp_short_o !== cs || ref_code_o !== rfe || ramp_done_o !== dn || reg_en_o !== en) begin
      errors++;
      $display("FAIL %s: got cs=%0b ref=%0d done=%0b en=%0b, expected cs=%0b ref=%0d done=%0b en=%0b",
               rq, comp_short_o, ref_code_o, ramp_done_o, reg_en_o, cs, rfe, dn, en);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  // Called at the first clamp cycle; returns at the ramp-done cycle.
  task automatic expect_soft(input bit uv, input bit st, input string why);
    for (int i = 0; i < L; i++) begin
      uv_i = uv; start_i = st;
      chk(1'b1, 0, 1'b0, 1'b1, {"R2 clamp ", why});
      step();
    end
    for (int i = 0; i < L; i++) begin
      uv_i = uv; start_i = st;
      chk(1'b0, i, 1'b0, 1'b1, {"R3 ramp ", why});
      step();
    end
    start_i = 1'b0;
    chk(1'b0, MAXC, 1'b1, 1'b1, {"R4 done ", why});
  endtask

  // Called at the first hold cycle; returns at the first retry clamp cycle.
  task automatic expect_hiccup(input string why);
    for (int i = 0; i < HP * L; i++) begin
      chk(1'b0, 0, 1'b0, 1'b0, {"R5 hold ", why});
      step();
    end
  endtask

  task automatic abort_now();
    abort_i = 1'b1;
    step();
    abort_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; uv_i = 1'b0; run_ok_i = 1'b1;
    repeat (3) step();
    chk(1'b0, 0, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(1'b0, 0, 1'b0, 1'b0, "R1 idle");
    end

    // R11: abort wins over start in idle
    start_i = 1'b1; abort_i = 1'b1;
    step();
    start_i = 1'b0; abort_i = 1'b0;
    chk(1'b0, 0, 1'b0, 1'b0, "R11 start+abort");
    step();
    chk(1'b0, 0, 1'b0, 1'b0, "R11 still idle");

    // R2 R3 R4 plain start
    pulse_start();
    expect_soft(1'b0, 1'b0, "first");
    for (int i = 0; i < 5; i++) begin
      step();
      chk(1'b0, MAXC, 1'b0, 1'b1, "R4 hold full scale");
    end

    // R8: uv without run qualify is ignored
    run_ok_i = 1'b0; uv_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(1'b0, MAXC, 1'b0, 1'b1, "R8 uv unqualified");
    end
    run_ok_i = 1'b1;
    step();
    uv_i = 1'b0;
    expect_hiccup("R5 single");
    expect_soft(1'b0, 1'b0, "R5 retry");
    step();
    chk(1'b0, MAXC, 1'b0, 1'b1, "R5 steady after retry");

    // R7 R10: uv and start held through clamp and ramp
    abort_now();
    chk(1'b0, 0, 1'b0, 1'b0, "R9 abort in active");
    pulse_start();
    expect_soft(1'b1, 1'b1, "R7 R10 masked");
    uv_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(1'b0, MAXC, 1'b0, 1'b1, "R7 R10 no effect");
    end

    // R6: persistent undervoltage repeats the hiccup
    uv_i = 1'b1;
    step();
    expect_hiccup("R6 first");
    expect_soft(1'b1, 1'b0, "R6 retry one");
    step();
    expect_hiccup("R6 second");
    uv_i = 1'b0;
    expect_soft(1'b0, 1'b0, "R6 recovered");
    for (int i = 0; i < 4; i++) begin
      step();
      chk(1'b0, MAXC, 1'b0, 1'b1, "R6 steady");
    end

    // R9: abort inside clamp, ramp and active, then clean restart
    for (int k = 0; k < 3; k++) begin
      int off;
      off = (k == 0) ? 3 : (k == 1) ? (L + 5) : (2 * L + 6);
      abort_now();
      pulse_start();
      repeat (off) step();
      abort_now();
      chk(1'b0, 0, 1'b0, 1'b0, "R9 abort mid phase");
      for (int i = 0; i < 3; i++) begin
        step();
        chk(1'b0, 0, 1'b0, 1'b0, "R9 stays idle");
      end
      pulse_start();
      expect_soft(1'b0, 1'b0, "R9 restart");
    end

    // R9: abort inside the hiccup hold
    uv_i = 1'b1;
    step();
    uv_i = 1'b0;
    repeat (7) step();
    abort_now();
    chk(1'b0, 0, 1'b0, 1'b0, "R9 abort in hold");
    for (int i = 0; i < 2 * HP * L; i++) begin
      step();
      if (i % 8 == 0) chk(1'b0, 0, 1'b0, 1'b0, "R9 no retry after abort");
    end
    pulse_start();
    expect_soft(1'b0, 1'b0, "R9 restart after hold");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule